// File: doc/BRIEF.md
# AHB-Lite Address-Phase Master With Selectable Wait-State Retraction

This block is the address-phase control stage of an AHB-Lite bus master. A requester presents one transfer at a time on a simple valid/ready interface. The block registers the request onto the bus as the transfer type, address, direction, size, burst kind and protection bits. It also holds the write data so it can present it in the following data phase. Read data and the error response are passed straight back to the requester and qualified with a response-valid strobe.

A build-time parameter, `STRICT_HOLD`, decides what happens while the slave stretches an address phase by holding `hready` low.

- With `STRICT_HOLD = 0` (retracting mode), a transfer that the slave has not yet taken can be withdrawn with `req_cancel`, which returns the bus to IDLE. It can also be overwritten by a newer request. A withdrawn or overwritten transfer is simply lost; the block never reissues it.
- With `STRICT_HOLD = 1`, a transfer on the bus stays exactly as issued until the slave takes it. Cancels are ignored and new requests are stalled.

In both modes an IDLE address slot may be filled with a new transfer during a wait state. Bursts are either single transfers or undefined-length incrementing sequences. BUSY is never driven.

Top module: `ahb_addr_master`

## Requirements
- R1: While reset is low and on the first edge after it, `htrans` is IDLE (2'b00), `haddr` is zero, `hwrite` is 0 and `rsp_valid` is 0.
- R2: When `req_valid` is high and `hready` is high, `req_ready` is high. On the next edge `htrans` becomes NONSEQ (2'b10), or SEQ (2'b11) when `req_seq` is set. `haddr`, `hwrite` and `hsize` take the request's values, and `hburst` becomes SINGLE (3'b000), or INCR (3'b001) when `req_incr` is set. BUSY (2'b01) never appears.
- R3: An active transfer counts as taken only on an edge where `hready` is high (`xfer_accept` high). If no new request is loaded on that edge, `htrans` returns to IDLE.
- R4: In both modes, when `htrans` is IDLE and `hready` is low, a valid request is loaded (`req_ready` high) and appears as NONSEQ on the next edge.
- R5: With `STRICT_HOLD = 1`, while an active transfer waits on low `hready`, `req_ready` stays low, `req_cancel` has no effect, and `htrans`, `haddr`, `hwrite`, `hsize`, `hburst` and `hprot` stay unchanged until the transfer is taken.
- R6: With `STRICT_HOLD = 0`, `req_cancel` during a waited active transfer turns `htrans` to IDLE on the next edge. The dropped transfer is never taken and never reissued.
- R7: With `STRICT_HOLD = 0`, a valid request without cancel during a waited active transfer is taken (`req_ready` high) and replaces the pending transfer's address and control on the next edge.
- R8: `req_cancel` has no effect when `hready` is high or when `htrans` is IDLE. The pending transfer is still taken, and a valid request in an idle slot is still loaded.
- R9: In both modes, a waited active transfer with neither `req_valid` nor `req_cancel` is held unchanged.
- R10: A request with `req_fetch` set is driven as a word read: `hsize` is 3'b010, `haddr[1:0]` is 2'b00, `hwrite` is 0 and `hprot[0]` is 0. A data request drives `hprot[0]` as 1.
- R11: `hwdata` shows the write data of a transfer from the edge that takes it until the next transfer is taken.
- R12: `rsp_valid` is high in the first cycle after a transfer is taken in which `hready` is high. `rsp_rdata` follows `hrdata`, and `rsp_err` is `hresp` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request loaded onto the bus this edge |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | 1 = write |
| req_size | input | 3 | Transfer size code |
| req_incr | input | 1 | Part of an incrementing burst |
| req_seq | input | 1 | Continuation beat of a burst |
| req_fetch | input | 1 | Instruction fetch (forced word read) |
| req_cancel | input | 1 | Withdraw the waited transfer (retracting mode) |
| req_wdata | input | DW | Write data of the request |
| xfer_accept | output | 1 | Active transfer taken this edge |
| rsp_valid | output | 1 | Data phase completes this cycle |
| rsp_rdata | output | DW | Read data to the requester |
| rsp_err | output | 1 | Error response on the completing data phase |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Bus burst kind |
| hprot | output | 4 | Bus protection bits |
| hwdata | output | DW | Bus write data |
| hready | input | 1 | Slave ready |
| hresp | input | 1 | Slave error response |
| hrdata | input | DW | Bus read data |

## Verification
The properties assume that `hready`, `req_valid` and `req_cancel` are settled levels at each rising edge. The hold checks also assume that a requester leaves `req_valid` and `req_cancel` low when it wants a waited transfer kept, so any change seen after such a cycle is the block's own fault. The stimulus changes inputs only one time unit after a rising edge and keeps wait stretches to a few cycles. One stream of inputs drives a retracting instance and a strict instance side by side, and each scenario predicts both results.

// File: rtl/ahb_addr_master.sv
module ahb_addr_master #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit STRICT_HOLD = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [2:0]    req_size,
  input  logic          req_incr,
  input  logic          req_seq,
  input  logic          req_fetch,
  input  logic          req_cancel,
  input  logic [DW-1:0] req_wdata,
  output logic          xfer_accept,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [3:0]    hprot,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic          hresp,
  input  logic [DW-1:0] hrdata
);
  localparam int ALIGN = $clog2(DW / 8);
  localparam logic [2:0] FETCH_SIZE = 3'(ALIGN);
  localparam logic [AW-1:0] FETCH_MASK = ~(AW'((1 << ALIGN) - 1));
  localparam logic [1:0] T_IDLE = 2'b00;
  localparam logic [1:0] T_NONSEQ = 2'b10;
  localparam logic [1:0] T_SEQ = 2'b11;
  localparam logic [2:0] B_SINGLE = 3'b000;
  localparam logic [2:0] B_INCR = 3'b001;

  logic          waited;
  logic          drop;
  logic          dphase_q;
  logic [DW-1:0] wdata_q;

  // a transfer is outstanding on the bus but the slave is stretching it
  assign waited      = !hready && htrans[1];
  assign drop        = !STRICT_HOLD && waited && req_cancel;
  assign req_ready   = req_valid && !drop && !(STRICT_HOLD && waited);
  assign xfer_accept = hready && htrans[1];
  assign rsp_valid   = dphase_q && hready;
  assign rsp_rdata   = hrdata;
  assign rsp_err     = rsp_valid && hresp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htrans   <= T_IDLE;
      haddr    <= '0;
      hwrite   <= 1'b0;
      hsize    <= '0;
      hburst   <= B_SINGLE;
      hprot    <= '0;
      wdata_q  <= '0;
      hwdata   <= '0;
      dphase_q <= 1'b0;
    end else begin
      if (req_ready) begin
        htrans  <= req_seq ? T_SEQ : T_NONSEQ;
        haddr   <= req_fetch ? (req_addr & FETCH_MASK) : req_addr;
        hwrite  <= req_write && !req_fetch;
        hsize   <= req_fetch ? FETCH_SIZE : req_size;
        hburst  <= req_incr ? B_INCR : B_SINGLE;
        hprot   <= {2'b00, 1'b1, !req_fetch};
        wdata_q <= req_wdata;
      end else if (drop || hready) begin
        htrans <= T_IDLE;
      end
      if (hready) dphase_q <= htrans[1];
      if (xfer_accept) hwdata <= wdata_q;
    end
  end
endmodule

// File: rtl/ahb_addr_master_sva.sv
module ahb_addr_master_sva #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit STRICT_HOLD = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hready,
  input logic          req_valid,
  input logic          req_cancel,
  input logic          req_ready,
  input logic [1:0]    htrans,
  input logic [AW-1:0] haddr,
  input logic          hwrite,
  input logic [2:0]    hsize,
  input logic [2:0]    hburst,
  input logic [3:0]    hprot,
  input logic          rsp_valid
);
  localparam logic [2:0] WORD = 3'($clog2(DW / 8));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (htrans == 2'b00 && haddr == '0 && !hwrite));

  assert_no_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    htrans != 2'b01);

  assert_accept_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans[1] && !req_ready) |=> htrans == 2'b00);

  assert_idle_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && htrans == 2'b00 && req_valid) |-> req_ready);

  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && htrans[1] && !req_valid && !req_cancel) |=>
      ($stable(htrans) && $stable(haddr) && $stable(hwrite) && $stable(hsize) && $stable(hburst)));

  generate
    if (STRICT_HOLD) begin : g_strict
      assert_strict_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && htrans[1]) |=>
          ($stable(htrans) && $stable(haddr) && $stable(hwrite) && $stable(hsize) &&
           $stable(hburst) && $stable(hprot)));
      assert_strict_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && htrans[1]) |-> !req_ready);
    end else begin : g_retract
      assert_cancel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && htrans[1] && req_cancel) |=> htrans == 2'b00);
      assert_replace_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && htrans[1] && req_valid && !req_cancel) |-> req_ready);
    end
  endgenerate

  assert_fetch_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && !hprot[0]) |-> (hsize == WORD && haddr[1:0] == 2'b00 && !hwrite));

  assert_rsp_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans[1]) |=> (rsp_valid == hready));
endmodule

bind ahb_addr_master ahb_addr_master_sva #(.AW(AW), .DW(DW), .STRICT_HOLD(STRICT_HOLD)) u_sva (
  .clk(clk), .rst_n(rst_n), .hready(hready), .req_valid(req_valid), .req_cancel(req_cancel),
  .req_ready(req_ready), .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hsize(hsize),
  .hburst(hburst), .hprot(hprot), .rsp_valid(rsp_valid)
);

// File: tb/ahb_addr_master_bench.sv
module ahb_addr_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_incr = 0, req_seq = 0, req_fetch = 0, req_cancel = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, hrdata = 0;
  logic [2:0]  req_size = 3'b010;
  logic        hready = 1, hresp = 0;

  logic        rdy_r, acc_r, rv_r, err_r, wr_r, rdy_s, acc_s, rv_s, err_s, wr_s;
  logic [31:0] rd_r, ad_r, wd_r, rd_s, ad_s, wd_s;
  logic [1:0]  tr_r, tr_s;
  logic [2:0]  sz_r, bu_r, sz_s, bu_s;
  logic [3:0]  pr_r, pr_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ahb_addr_master #(.STRICT_HOLD(1'b0)) u_ahb_addr_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_r), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_incr(req_incr), .req_seq(req_seq),
    .req_fetch(req_fetch), .req_cancel(req_cancel), .req_wdata(req_wdata), .xfer_accept(acc_r),
    .rsp_valid(rv_r), .rsp_rdata(rd_r), .rsp_err(err_r), .haddr(ad_r), .htrans(tr_r),
    .hwrite(wr_r), .hsize(sz_r), .hburst(bu_r), .hprot(pr_r), .hwdata(wd_r),
    .hready(hready), .hresp(hresp), .hrdata(hrdata));

  ahb_addr_master #(.STRICT_HOLD(1'b1)) u_ahb_addr_master_strict (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_s), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_incr(req_incr), .req_seq(req_seq),
    .req_fetch(req_fetch), .req_cancel(req_cancel), .req_wdata(req_wdata), .xfer_accept(acc_s),
    .rsp_valid(rv_s), .rsp_rdata(rd_s), .rsp_err(err_s), .haddr(ad_s), .htrans(tr_s),
    .hwrite(wr_s), .hsize(sz_s), .hburst(bu_s), .hprot(pr_s), .hwdata(wd_s),
    .hready(hready), .hresp(hresp), .hrdata(hrdata));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    req_valid = 0; req_cancel = 0; req_seq = 0; req_incr = 0; req_fetch = 0;
    req_write = 0; req_size = 3'b010; hready = 1; hresp = 0;
  endtask

  task automatic load(logic [31:0] a, logic w, logic [31:0] d, logic incr, logic seq);
    req_valid = 1; req_addr = a; req_write = w; req_wdata = d; req_incr = incr; req_seq = seq;
  endtask

  task automatic flush();
    quiet();
    tick(); tick();
  endtask

  task automatic t_reset();
    chk("R1 htrans retract", tr_r, 2'b00);
    chk("R1 htrans strict", tr_s, 2'b00);
    chk("R1 haddr", {ad_r, ad_s}, 64'h0);
    chk("R1 rsp_valid/hwrite", {rv_r, rv_s, wr_r, wr_s}, 4'b0000);
  endtask

  task automatic t_single();
    load(32'h100, 1, 32'hAA, 0, 0);
    #1 chk("R2 req_ready", {rdy_r, rdy_s}, 2'b11);
    tick();
    chk("R2 htrans nonseq", {tr_r, tr_s}, 4'b1010);
    chk("R2 addr/burst", {ad_r, bu_r, wr_r}, {32'h100, 3'b000, 1'b1});
    quiet(); hrdata = 32'hDEAD_BEEF;
    #1 chk("R3 xfer_accept", {acc_r, acc_s}, 2'b11);
    tick();
    chk("R3 back to idle", {tr_r, tr_s}, 4'b0000);
    chk("R11 hwdata", {wd_r, wd_s}, {32'hAA, 32'hAA});
    chk("R12 rsp_valid", {rv_r, rv_s}, 2'b11);
    chk("R12 rsp_rdata", rd_r, 32'hDEAD_BEEF);
    tick();
    chk("R12 rsp ends", {rv_r, rv_s}, 2'b00);
  endtask

  task automatic t_burst();
    load(32'h200, 0, 0, 1, 0);
    tick();
    chk("R2 incr nonseq", {tr_r, bu_r}, {2'b10, 3'b001});
    load(32'h204, 0, 0, 1, 1);
    tick();
    chk("R2 seq beat", {tr_r, tr_s, ad_r, bu_s}, {2'b11, 2'b11, 32'h204, 3'b001});
    flush();
  endtask

  task automatic t_hold();
    load(32'h280, 0, 0, 0, 0);
    tick();
    quiet(); hready = 0;
    tick(); tick();
    chk("R9 held retract", {tr_r, ad_r}, {2'b10, 32'h280});
    chk("R9 held strict", {tr_s, ad_s}, {2'b10, 32'h280});
    hready = 1;
    tick();
    chk("R3 taken after wait", {tr_r, tr_s}, 4'b0000);
    flush();
  endtask

  task automatic t_cancel();
    load(32'h300, 0, 0, 0, 0);
    tick();
    quiet(); hready = 0; req_cancel = 1;
    #1 chk("R5 strict no ready", rdy_s, 1'b0);
    tick();
    chk("R6 retract dropped", tr_r, 2'b00);
    chk("R5 strict keeps", {tr_s, ad_s}, {2'b10, 32'h300});
    req_cancel = 0; hready = 1;
    tick();
    chk("R6 never taken", {rv_r, rv_s}, 2'b01);
    tick();
    chk("R6 not reissued", {tr_r, tr_s}, 4'b0000);
    flush();
  endtask

  task automatic t_replace();
    load(32'h400, 1, 32'h11, 0, 0);
    tick();
    quiet(); hready = 0;
    load(32'h500, 0, 32'h22, 1, 0);
    #1 chk("R7 retract ready", rdy_r, 1'b1);
    chk("R5 strict stalls", rdy_s, 1'b0);
    tick();
    chk("R7 replaced", {tr_r, ad_r, wr_r, bu_r}, {2'b10, 32'h500, 1'b0, 3'b001});
    chk("R5 strict unchanged", {tr_s, ad_s, wr_s, bu_s}, {2'b10, 32'h400, 1'b1, 3'b000});
    quiet();
    tick();
    chk("R11 strict wdata", wd_s, 32'h11);
    chk("R3 both idle", {tr_r, tr_s}, 4'b0000);
    flush();
  endtask

  task automatic t_idle_fill();
    hready = 0;
    load(32'h600, 0, 0, 0, 0);
    #1 chk("R4 ready while waited idle", {rdy_r, rdy_s}, 2'b11);
    tick();
    chk("R4 nonseq", {tr_r, tr_s, ad_s}, {2'b10, 2'b10, 32'h600});
    flush();
  endtask

  task automatic t_cancel_ignored();
    load(32'h700, 0, 0, 0, 0);
    tick();
    quiet(); req_cancel = 1;
    tick();
    chk("R8 taken despite cancel", {rv_r, rv_s}, 2'b11);
    load(32'h780, 0, 0, 0, 0); hready = 0;
    #1 chk("R8 idle slot ready", {rdy_r, rdy_s}, 2'b11);
    tick();
    chk("R8 idle slot loaded", {tr_r, ad_r}, {2'b10, 32'h780});
    flush();
  endtask

  task automatic t_fetch();
    load(32'h803, 1, 0, 0, 0); req_fetch = 1; req_size = 3'b000;
    tick();
    chk("R10 fetch retract", {ad_r, sz_r, wr_r, pr_r[0]}, {32'h800, 3'b010, 1'b0, 1'b0});
    chk("R10 fetch strict", {ad_s, sz_s, wr_s, pr_s[0]}, {32'h800, 3'b010, 1'b0, 1'b0});
    req_fetch = 0; req_addr = 32'h810; req_write = 0;
    tick();
    chk("R10 data hprot", {pr_r[0], pr_s[0]}, 2'b11);
    flush();
  endtask

  task automatic t_data_wait();
    load(32'h900, 1, 32'h55, 0, 0);
    tick();
    quiet();
    tick();
    hready = 0;
    #1 chk("R12 waited data phase", {rv_r, rv_s}, 2'b00);
    tick();
    chk("R11 hwdata held", {wd_r, wd_s}, {32'h55, 32'h55});
    hready = 1; hresp = 1;
    #1 chk("R12 completes with error", {rv_r, err_r, rv_s, err_s}, 4'b1111);
    flush();
  endtask

  initial begin
    #1 t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    tick();
    t_reset();
    t_single();
    t_burst();
    t_hold();
    t_cancel();
    t_replace();
    t_idle_fill();
    t_cancel_ignored();
    t_fetch();
    t_data_wait();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule